// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block produces the byte address stream for one side (read or write) of a DMA channel. A transfer block is a number of frames, and each frame is a number of elements. Software programs an initial address, an element width, element and frame counts, two signed strides and an addressing mode. These go through a narrow write-only register port. A start pulse then arms the generator. It hands out one address per element over a valid/ready stream and marks the last element of each frame and of the block.

The double-strided mode applies one signed index between elements and a different signed index at each frame boundary. Each index is biased by the element width minus one. With a suitable start address, this lets the same counters walk a framebuffer rotated by 90, 180 or 270 degrees, or mirrored. A trigger input sets how much of the block is released at a time: a single element, a whole frame, or the whole block. A repeat option reloads the block on completion, so the walk runs again with no software action.

Back-pressure: once `addr_valid` is high, it stays high, and `addr_out`, `addr_eof` and `addr_eob` stay unchanged, until a cycle in which `addr_ready` is high. That cycle accepts the element. `addr_valid` never depends on `addr_ready`.

Top module: `dix_addr_gen`

## Requirements
- R1: After reset, `addr_valid` is low and stays low until a start pulse and a trigger have both been seen.
- R2: Register map (addresses on `cfg_addr`): 0 control, 1 and 2 initial address low and high halves, 3 element count, 4 frame count, 5 element index, 6 and 7 frame index low and high halves. Control bits 1:0 give the element width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. The first address of a block is the initial address.
- R3: The mode field sits at control bits 13:12, or at bits 15:14 when the block is instantiated with `DEST_SIDE=1`. Mode 0 repeats the same address. Mode 1 adds the element width after every element. Both modes ignore the two indices.
- R4: Mode 2 moves every step, including the step at a frame boundary, by element width + element index − 1.
- R5: Mode 3 moves by element width + element index − 1 inside a frame, and by element width + frame index − 1 after a frame's last element. The element index is 16-bit signed. The frame index is 32-bit signed.
- R6: `addr_eof` is high with the last element of each frame. `addr_eob` is high with the last element of the last frame. A count of 0 is treated as 1.
- R7: Control bit 6 selects one block per trigger. Otherwise, bit 5 selects one frame per trigger. With neither bit set, each trigger releases one element. A trigger that arrives while a release is still in progress is dropped.
- R8: While `addr_valid` is high and `addr_ready` is low, the address and both flags hold steady.
- R9: After the last element, with control bit 8 clear the generator goes idle. With bit 8 set it reloads the block and waits for the next trigger.
- R10: Register writes made during a block only take effect at the next start pulse or the next repeat reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| start | input | 1 | Snapshot the registers and arm a new block |
| trig | input | 1 | Synchronization event that releases the next element, frame or block |
| addr_valid | output | 1 | An element address is offered |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_out | output | ADDR_W | Byte address of the current element |
| addr_eof | output | 1 | Current element ends a frame |
| addr_eob | output | 1 | Current element ends the block |

## Verification
A trigger sampled at one clock edge makes `addr_valid` visible in the next cycle. An accepted element shows its successor address, or a dropped `addr_valid` at a sync-window close, in the cycle after the accepting edge. A register write or start pulse takes effect at the edge that samples it. The bench drives every input on the falling edge and samples one nanosecond later. It waits a bounded number of cycles for `addr_valid` and then compares the address and flags against a stride model that works only from the requirement formulas. After every window close it checks that `addr_valid` is low in the very next cycle.

// File: rtl/dix_pkg.sv
package dix_pkg;
  typedef enum logic [1:0] {
    AM_CONST  = 2'd0,
    AM_INC    = 2'd1,
    AM_SINGLE = 2'd2,
    AM_DOUBLE = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    SY_ELEM  = 2'd0,
    SY_FRAME = 2'd1,
    SY_BLOCK = 2'd2
  } sync_e;

  localparam int REG_SEL_W = 3;
  localparam int REG_DAT_W = 16;
endpackage

// File: rtl/dix_cfg_regs.sv
module dix_cfg_regs
  import dix_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter bit DEST_SIDE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_SEL_W-1:0] sel,
  input  logic [REG_DAT_W-1:0] wdata,
  output logic [ADDR_W-1:0]    base_addr,
  output logic [1:0]           dtype,
  output amode_e               amode,
  output sync_e                sync,
  output logic                 rep_en,
  output logic [CNT_W-1:0]     ecnt,
  output logic [CNT_W-1:0]     fcnt,
  output logic [15:0]          eidx,
  output logic [31:0]          fidx
);
  logic [15:0] ctrl_q;
  logic [31:0] base_q;
  logic [CNT_W-1:0] ecnt_q, fcnt_q;
  logic [15:0] eidx_q;
  logic [31:0] fidx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      ecnt_q <= '0;
      fcnt_q <= '0;
      eidx_q <= '0;
      fidx_q <= '0;
    end else if (we) begin
      case (sel)
        3'd0: ctrl_q        <= wdata;
        3'd1: base_q[15:0]  <= wdata;
        3'd2: base_q[31:16] <= wdata;
        3'd3: ecnt_q        <= wdata[CNT_W-1:0];
        3'd4: fcnt_q        <= wdata[CNT_W-1:0];
        3'd5: eidx_q        <= wdata;
        3'd6: fidx_q[15:0]  <= wdata;
        default: fidx_q[31:16] <= wdata;
      endcase
    end
  end

  generate
    if (DEST_SIDE) begin : g_dst
      assign amode = amode_e'(ctrl_q[15:14]);
    end else begin : g_src
      assign amode = amode_e'(ctrl_q[13:12]);
    end
  endgenerate

  assign base_addr = base_q[ADDR_W-1:0];
  assign dtype     = ctrl_q[1:0];
  assign sync      = ctrl_q[6] ? SY_BLOCK : (ctrl_q[5] ? SY_FRAME : SY_ELEM);
  assign rep_en    = ctrl_q[8];
  assign ecnt      = ecnt_q;
  assign fcnt      = fcnt_q;
  assign eidx      = eidx_q;
  assign fidx      = fidx_q;
endmodule

// File: rtl/dix_step_calc.sv
module dix_step_calc
  import dix_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        dtype,
  input  amode_e            amode,
  input  logic              frame_end,
  input  logic [15:0]       eidx,
  input  logic [31:0]       fidx,
  output logic [ADDR_W-1:0] nxt
);
  localparam int SW = 34;

  logic signed [SW-1:0] es_x, ei_x, fi_x, step;

  always_comb begin
    case (dtype)
      2'd0:    es_x = SW'(1);
      2'd1:    es_x = SW'(2);
      default: es_x = SW'(4);
    endcase
    ei_x = {{(SW-16){eidx[15]}}, eidx};
    fi_x = {{(SW-32){fidx[31]}}, fidx};
    case (amode)
      AM_CONST:  step = '0;
      AM_INC:    step = es_x;
      AM_SINGLE: step = es_x + ei_x - SW'(1);
      default:   step = frame_end ? (es_x + fi_x - SW'(1))
                                  : (es_x + ei_x - SW'(1));
    endcase
  end

  assign nxt = cur + step[ADDR_W-1:0];
endmodule

// File: rtl/dix_seq.sv
module dix_seq
  import dix_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              trig,
  input  logic [ADDR_W-1:0] c_base,
  input  logic [1:0]        c_dtype,
  input  amode_e            c_amode,
  input  sync_e             c_sync,
  input  logic              c_rep,
  input  logic [CNT_W-1:0]  c_ecnt,
  input  logic [CNT_W-1:0]  c_fcnt,
  input  logic [15:0]       c_eidx,
  input  logic [31:0]       c_fidx,
  output logic              valid,
  input  logic              ready,
  output logic [ADDR_W-1:0] addr,
  output logic              eof,
  output logic              eob
);
  logic [1:0]       a_dtype;
  amode_e           a_amode;
  sync_e            a_sync;
  logic             a_rep;
  logic [CNT_W-1:0] a_ecnt, a_fcnt;
  logic [15:0]      a_eidx;
  logic [31:0]      a_fidx;

  logic [ADDR_W-1:0] cur, nxt;
  logic [CNT_W-1:0]  e_pos, f_pos;
  logic busy, open;
  logic last_e, last_f, acc, blk_end, reload;

  assign last_e  = ({1'b0, e_pos} + 1'b1) >= {1'b0, a_ecnt};
  assign last_f  = ({1'b0, f_pos} + 1'b1) >= {1'b0, a_fcnt};
  assign valid   = busy & open;
  assign acc     = valid & ready;
  assign blk_end = acc & last_e & last_f;
  assign reload  = start | (blk_end & a_rep);

  dix_step_calc #(.ADDR_W(ADDR_W)) u_step (
    .cur(cur), .dtype(a_dtype), .amode(a_amode), .frame_end(last_e),
    .eidx(a_eidx), .fidx(a_fidx), .nxt(nxt)
  );

  // Active snapshot: only refreshed at start or repeat reload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_dtype <= '0; a_amode <= AM_CONST; a_sync <= SY_ELEM; a_rep <= 1'b0;
      a_ecnt  <= '0; a_fcnt  <= '0; a_eidx <= '0; a_fidx <= '0;
    end else if (reload) begin
      a_dtype <= c_dtype; a_amode <= c_amode; a_sync <= c_sync; a_rep <= c_rep;
      a_ecnt  <= c_ecnt;  a_fcnt  <= c_fcnt;  a_eidx <= c_eidx; a_fidx <= c_fidx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0; e_pos <= '0; f_pos <= '0; busy <= 1'b0; open <= 1'b0;
    end else if (reload) begin
      cur <= c_base; e_pos <= '0; f_pos <= '0; busy <= 1'b1; open <= 1'b0;
    end else if (busy) begin
      if (!open && trig) open <= 1'b1;
      if (acc) begin
        if (last_e && last_f) begin
          busy <= 1'b0;
          open <= 1'b0;
        end else if (last_e) begin
          cur   <= nxt;
          e_pos <= '0;
          f_pos <= f_pos + 1'b1;
          if (a_sync != SY_BLOCK) open <= 1'b0;
        end else begin
          cur   <= nxt;
          e_pos <= e_pos + 1'b1;
          if (a_sync == SY_ELEM) open <= 1'b0;
        end
      end
    end
  end

  assign addr = cur;
  assign eof  = valid & last_e;
  assign eob  = valid & last_e & last_f;

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !start) |=> (valid && $stable(addr) && $stable(eof) && $stable(eob)));
  // R7
  elem_window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && a_sync == SY_ELEM && !start) |=> !valid);
  // R7
  frame_window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && eof && a_sync == SY_FRAME && !start) |=> !valid);
  // R3
  const_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !eob && a_amode == AM_CONST && !start) |=> $stable(addr));
  // R3
  inc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !eob && a_amode == AM_INC && a_dtype == 2'd1 && !start)
      |=> (addr == $past(addr) + ADDR_W'(2)));
  // R9
  idle_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !a_rep && !start) |=> !valid);
endmodule

// File: rtl/dix_addr_gen.sv
module dix_addr_gen
  import dix_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter bit DEST_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              start,
  input  logic              trig,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_eof,
  output logic              addr_eob
);
  logic [ADDR_W-1:0] c_base;
  logic [1:0]        c_dtype;
  amode_e            c_amode;
  sync_e             c_sync;
  logic              c_rep;
  logic [CNT_W-1:0]  c_ecnt, c_fcnt;
  logic [15:0]       c_eidx;
  logic [31:0]       c_fidx;

  dix_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEST_SIDE(DEST_SIDE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .base_addr(c_base), .dtype(c_dtype), .amode(c_amode), .sync(c_sync),
    .rep_en(c_rep), .ecnt(c_ecnt), .fcnt(c_fcnt), .eidx(c_eidx), .fidx(c_fidx)
  );

  dix_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .trig(trig),
    .c_base(c_base), .c_dtype(c_dtype), .c_amode(c_amode), .c_sync(c_sync),
    .c_rep(c_rep), .c_ecnt(c_ecnt), .c_fcnt(c_fcnt), .c_eidx(c_eidx),
    .c_fidx(c_fidx), .valid(addr_valid), .ready(addr_ready), .addr(addr_out),
    .eof(addr_eof), .eob(addr_eob)
  );
endmodule

// File: tb/sim_dix_addr_gen.sv
`timescale 1ns/1ps
module sim_dix_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        trig = 1'b0;
  logic        addr_ready = 1'b1;
  logic        addr_valid, addr_eof, addr_eob;
  logic [31:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dix_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .trig(trig), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_out(addr_out), .addr_eof(addr_eof),
    .addr_eob(addr_eob)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic cfg(input logic [15:0] ctrl, input logic [31:0] base, input logic [15:0] ne,
                     input logic [15:0] nf, input logic [15:0] ei, input logic [31:0] fi);
    wr(3'd0, ctrl);      wr(3'd1, base[15:0]); wr(3'd2, base[31:16]);
    wr(3'd3, ne);        wr(3'd4, nf);         wr(3'd5, ei);
    wr(3'd6, fi[15:0]);  wr(3'd7, fi[31:16]);
  endtask

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1; step(); trig = 1'b0;
  endtask

  task automatic expect_beat(input logic [31:0] a, input bit e_eof, input bit e_eob, input string tag);
    for (int i = 0; i < 8; i++) begin
      if (addr_valid) break;
      step();
    end
    chk(addr_valid, {tag, " valid"}, 32'(addr_valid), 32'd1);
    chk(addr_out == a, {tag, " address"}, addr_out, a);
    chk(addr_eof == e_eof && addr_eob == e_eob, {tag, " flags eof/eob"},
        {30'd0, addr_eof, addr_eob}, {30'd0, e_eof, e_eob});
    step();
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] a, input int mode, input int es,
                                             input int ei, input int fi, input bit fend);
    case (mode)
      0:       return a;
      1:       return a + 32'(es);
      2:       return a + 32'(es + ei - 1);
      default: return fend ? a + 32'(es + fi - 1) : a + 32'(es + ei - 1);
    endcase
  endfunction

  // sync: 0 element, 1 frame, 2 block
  task automatic run_seq(input logic [31:0] base, input int ne, input int nf, input int mode,
                         input int es, input int ei, input int fi, input int sync, input string tag);
    logic [31:0] a = base;
    int ne_e = (ne == 0) ? 1 : ne;
    int nf_e = (nf == 0) ? 1 : nf;
    for (int f = 0; f < nf_e; f++) begin
      for (int e = 0; e < ne_e; e++) begin
        bit fend = (e == ne_e - 1);
        bit lastb = fend && (f == nf_e - 1);
        if (sync == 0 || (sync == 1 && e == 0) || (sync == 2 && f == 0 && e == 0)) pulse_trig();
        expect_beat(a, fend, lastb, tag);
        if (!lastb && (sync == 0 || (sync == 1 && fend)))
          chk(!addr_valid, {tag, " R7 window closes"}, 32'(addr_valid), 32'd0);
        a = model_next(a, mode, es, ei, fi, fend);
      end
    end
  endtask

  task automatic t_reset();
    chk(!addr_valid, "R1 reset idle", 32'(addr_valid), 32'd0);
    pulse_trig();
    chk(!addr_valid, "R1 trigger without start", 32'(addr_valid), 32'd0);
  endtask

  task automatic t_postinc();
    // R3 R2: mode 1, 16-bit, block sync, indices programmed but ignored
    cfg(16'h1041, 32'h2000_0010, 16'd3, 16'd2, 16'd5, 32'd100);
    pulse_start();
    run_seq(32'h2000_0010, 3, 2, 1, 2, 5, 100, 2, "R3 post-inc");
    chk(!addr_valid, "R9 idle after block", 32'(addr_valid), 32'd0);
  endtask

  task automatic t_const();
    // R3 R7: mode 0, 32-bit, element sync; double trigger dropped
    cfg(16'h0002, 32'h0000_4440, 16'd2, 16'd1, 16'd9, 32'd9);
    pulse_start();
    addr_ready = 1'b0;
    pulse_trig();
    pulse_trig();
    addr_ready = 1'b1;
    expect_beat(32'h0000_4440, 1'b0, 1'b0, "R3 constant");
    chk(!addr_valid, "R7 extra trigger dropped", 32'(addr_valid), 32'd0);
    pulse_trig();
    expect_beat(32'h0000_4440, 1'b1, 1'b1, "R3 constant");
    chk(!addr_valid, "R9 idle after block", 32'(addr_valid), 32'd0);
  endtask

  task automatic t_single();
    // R4 R7: mode 2, 8-bit, frame sync, element index 3
    cfg(16'h2020, 32'h0000_0100, 16'd2, 16'd3, 16'd3, 32'd50);
    pulse_start();
    run_seq(32'h0000_0100, 2, 3, 2, 1, 3, 50, 1, "R4 single index");
  endtask

  task automatic t_rot90();
    // R5: 3x2 image of 16-bit pixels walked rotated by 90 degrees
    cfg(16'h3041, 32'h0000_1006, 16'd2, 16'd3, 16'hFFF9, 32'd7);
    pulse_start();
    run_seq(32'h0000_1006, 2, 3, 3, 2, -7, 7, 2, "R5 rotate90");
  endtask

  task automatic t_rot180();
    // R5: negative 32-bit frame index from both halves
    cfg(16'h3041, 32'h0000_100A, 16'd3, 16'd2, 16'hFFFD, 32'hFFFF_FFFD);
    pulse_start();
    run_seq(32'h0000_100A, 3, 2, 3, 2, -3, -3, 2, "R5 rotate180");
  endtask

  task automatic t_zero_count();
    // R6 R2: element count 0 acts as 1, 32-bit width
    cfg(16'h1042, 32'h0001_0000, 16'd0, 16'd2, 16'd0, 32'd0);
    pulse_start();
    run_seq(32'h0001_0000, 0, 2, 1, 4, 0, 0, 2, "R6 zero count");
  endtask

  task automatic t_stall();
    // R8: address held while ready is low
    cfg(16'h1041, 32'h0000_0800, 16'd2, 16'd1, 16'd0, 32'd0);
    pulse_start();
    addr_ready = 1'b0;
    pulse_trig();
    for (int i = 0; i < 3; i++) begin
      chk(addr_valid && addr_out == 32'h800 && !addr_eof, "R8 stall hold", addr_out, 32'h800);
      step();
    end
    addr_ready = 1'b1;
    expect_beat(32'h0000_0800, 1'b0, 1'b0, "R8 after stall");
    expect_beat(32'h0000_0802, 1'b1, 1'b1, "R8 after stall");
  endtask

  task automatic t_repeat();
    // R9 R10: repeat reload; mid-block writes deferred to reload
    cfg(16'h1141, 32'h0000_3000, 16'd2, 16'd1, 16'd0, 32'd0);
    pulse_start();
    pulse_trig();
    expect_beat(32'h0000_3000, 1'b0, 1'b0, "R10 block A");
    addr_ready = 1'b0;
    wr(3'd1, 16'h3100);
    wr(3'd3, 16'd1);
    addr_ready = 1'b1;
    expect_beat(32'h0000_3002, 1'b1, 1'b1, "R10 block A unchanged");
    chk(!addr_valid, "R9 reload waits for trigger", 32'(addr_valid), 32'd0);
    wr(3'd0, 16'h1041);
    pulse_trig();
    expect_beat(32'h0000_3100, 1'b1, 1'b1, "R10 reload takes new values");
    chk(!addr_valid, "R9 repeat still active", 32'(addr_valid), 32'd0);
    pulse_trig();
    expect_beat(32'h0000_3100, 1'b1, 1'b1, "R9 final block");
    pulse_trig();
    chk(!addr_valid, "R9 idle without repeat", 32'(addr_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_postinc();
    t_const();
    t_single();
    t_rot90();
    t_rot180();
    t_zero_count();
    t_stall();
    t_repeat();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule